// File: doc/BRIEF.md
# Byte Output Port with Polled and Vectored-Interrupt Service

This block is a byte-wide output peripheral on a 16-bit memory-mapped bus. It holds three registers: an outgoing byte, a status/control byte, and an interrupt vector byte. Software can use it in two ways. It can poll the ready flag before each write. It can also set the interrupt-enable bit and let the interrupt request line call a service routine. That routine checks the pending flag and then writes the next byte.

The outgoing byte is passed to a downstream device through a valid/accept handshake. After the device accepts a byte, the port waits a fixed recovery time (the `SETTLE` parameter) before it reports ready again. When the processor acknowledges an interrupt, the port puts its stored vector number on the read data bus. A device error input sets a sticky error flag, which software clears by writing to the status register.

Top module: `mmio_out_port`

## Requirements
- R1: After reset the status register reads 0x0080 (ready only), the vector register reads 0x000F, `irq` is low and `dev_valid` is low.
- R2: The byte register sits at `BASE`, status at `BASE`+2 and vector at `BASE`+4. A read of any other address returns 0, and a write to it changes no state.
- R3: A write to the byte register while ready is 1 stores the low byte. On the next cycle `dev_valid` goes high with that byte on `dev_byte`, and ready goes low. `dev_valid` and `dev_byte` hold until a cycle with `dev_accept` high. Reading the byte register returns the last stored byte.
- R4: A write to the byte register while ready is 0 is ignored: `dev_byte` and the byte readback keep their earlier value.
- R5: Ready returns to 1 exactly `SETTLE` clock edges after the edge that samples `dev_accept` with `dev_valid` high. While `dev_valid` is high, ready stays 0.
- R6: The status read value has ready in bit 7, interrupt enable in bit 2, pending in bit 1, error in bit 0, and zeros elsewhere. A status write loads bit 2 from the write data. Writes to bits 7 and 1 have no effect.
- R7: `irq` is high exactly when interrupt enable and ready are both 1.
- R8: Pending is set one cycle after ready rises while interrupt enable is 1. An accepted byte write clears it, and clear wins over set. A rise of ready while interrupts are disabled leaves pending at 0.
- R9: A cycle with `dev_err` high sets the error flag. A status write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. If both happen in the same cycle, the set wins.
- R10: While `iack` is high, `rdata` returns the vector byte zero-extended. This takes priority over any register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus byte address |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 16 | Bus write data (low byte used) |
| rdata | output | 16 | Bus read data, combinational |
| iack | input | 1 | Interrupt acknowledge cycle |
| irq | output | 1 | Interrupt request |
| dev_err | input | 1 | Downstream device error |
| dev_accept | input | 1 | Downstream device takes the byte |
| dev_valid | output | 1 | Byte offered to the device |
| dev_byte | output | 8 | Byte offered to the device |

## Verification
The hardest case to reach is the exact cycle in which pending appears. It has to be caught between the rise of ready and the next byte write, and this must also be shown with interrupts disabled, where pending must stay low. The stimulus first completes a transfer with interrupts disabled. It then enables interrupts, writes, accepts, and issues back-to-back status reads, one per cycle. This shows ready rising after exactly `SETTLE` edges and pending following one cycle later. A write made while the device still holds the previous byte, and a write of 1 to the ready bit, show which state the port refuses to change.

// File: rtl/mmio_out_pkg.sv
package mmio_out_pkg;
   localparam int OFS_BYTE = 0;
   localparam int OFS_STAT = 2;
   localparam int OFS_VECT = 4;
   localparam int BIT_RDY  = 7;
   localparam int BIT_IEN  = 2;
   localparam int BIT_PND  = 1;
   localparam int BIT_ERR  = 0;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_BYTE = 2'd1,
      SEL_STAT = 2'd2,
      SEL_VECT = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/mmio_out_decode.sv
module mmio_out_decode
   import mmio_out_pkg::*;
#(
   parameter int          ADDR_W = 16,
   parameter logic [15:0] BASE   = 16'h8000
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(BASE) + ADDR_W'(OFS_BYTE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE) + ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_VECT = ADDR_W'(BASE) + ADDR_W'(OFS_VECT);

   always_comb begin
      if (addr == A_BYTE)      sel = SEL_BYTE;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_VECT) sel = SEL_VECT;
      else                     sel = SEL_NONE;
   end
endmodule

// File: rtl/mmio_out_xfer.sv
module mmio_out_xfer #(
   parameter int BYTE_W = 8,
   parameter int SETTLE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_byte,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic              dev_accept,
   output logic              take,
   output logic              ready,
   output logic              ready_rise,
   output logic              dev_valid,
   output logic [BYTE_W-1:0] dev_byte
);
   localparam int CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

   logic handoff;
   assign take    = wr_byte & ready;
   assign handoff = dev_valid & dev_accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_valid <= 1'b0;
         dev_byte  <= '0;
      end else if (take) begin
         dev_valid <= 1'b1;
         dev_byte  <= wbyte;
      end else if (handoff) begin
         dev_valid <= 1'b0;
      end
   end

   generate
      if (SETTLE == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ready      <= 1'b1;
               ready_rise <= 1'b0;
            end else begin
               ready_rise <= 1'b0;
               if (take) begin
                  ready <= 1'b0;
               end else if (handoff) begin
                  ready      <= 1'b1;
                  ready_rise <= 1'b1;
               end
            end
         end
      end else begin : g_timed
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ready      <= 1'b1;
               ready_rise <= 1'b0;
               cnt        <= '0;
            end else begin
               ready_rise <= 1'b0;
               if (take) begin
                  ready <= 1'b0;
               end else if (handoff) begin
                  cnt <= CNT_W'(SETTLE);
               end else if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
                  if (cnt == CNT_W'(1)) begin
                     ready      <= 1'b1;
                     ready_rise <= 1'b1;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mmio_out_ctrl.sv
module mmio_out_ctrl
   import mmio_out_pkg::*;
#(
   parameter int                BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] VEC_RESET = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr,
   input  logic              vect_wr,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic              take,
   input  logic              ready_rise,
   input  logic              dev_err,
   output logic              ien,
   output logic              pend,
   output logic              err,
   output logic [BYTE_W-1:0] vect
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien  <= 1'b0;
         vect <= VEC_RESET;
      end else begin
         if (stat_wr) ien  <= wbyte[BIT_IEN];
         if (vect_wr) vect <= wbyte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pend <= 1'b0;
      else if (take)                pend <= 1'b0;
      else if (ready_rise && ien)   pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           err <= 1'b0;
      else if (dev_err)                     err <= 1'b1;
      else if (stat_wr && !wbyte[BIT_ERR])  err <= 1'b0;
   end
endmodule

// File: rtl/mmio_out_port.sv
module mmio_out_port
   import mmio_out_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 16,
   parameter int          BYTE_W    = 8,
   parameter logic [15:0] BASE      = 16'h8000,
   parameter int          SETTLE    = 2,
   parameter logic [7:0]  VEC_RESET = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              iack,
   output logic              irq,
   input  logic              dev_err,
   input  logic              dev_accept,
   output logic              dev_valid,
   output logic [BYTE_W-1:0] dev_byte
);
   initial begin
      if (BYTE_W < 8)       $error("BYTE_W must cover status bit 7");
      if (DATA_W < BYTE_W)  $error("DATA_W narrower than BYTE_W");
      if (BASE[0] != 1'b0)  $error("BASE must be even");
      if (SETTLE < 0)       $error("SETTLE must be non-negative");
   end

   reg_sel_e          sel;
   logic [BYTE_W-1:0] wbyte;
   logic              take, ready, ready_rise;
   logic              ien, pend, err;
   logic [BYTE_W-1:0] vect, stat;

   assign wbyte = wdata[BYTE_W-1:0];

   mmio_out_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .addr(addr), .sel(sel)
   );

   mmio_out_xfer #(.BYTE_W(BYTE_W), .SETTLE(SETTLE)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .wr_byte(wr_en && sel == SEL_BYTE), .wbyte(wbyte),
      .dev_accept(dev_accept), .take(take), .ready(ready),
      .ready_rise(ready_rise), .dev_valid(dev_valid), .dev_byte(dev_byte)
   );

   mmio_out_ctrl #(.BYTE_W(BYTE_W), .VEC_RESET(BYTE_W'(VEC_RESET))) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .stat_wr(wr_en && sel == SEL_STAT), .vect_wr(wr_en && sel == SEL_VECT),
      .wbyte(wbyte), .take(take), .ready_rise(ready_rise), .dev_err(dev_err),
      .ien(ien), .pend(pend), .err(err), .vect(vect)
   );

   always_comb begin
      stat          = '0;
      stat[BIT_RDY] = ready;
      stat[BIT_IEN] = ien;
      stat[BIT_PND] = pend;
      stat[BIT_ERR] = err;
   end

   assign irq = ien & ready;

   always_comb begin
      rdata = '0;
      if (iack) begin
         rdata[BYTE_W-1:0] = vect;
      end else if (rd_en) begin
         case (sel)
            SEL_BYTE: rdata[BYTE_W-1:0] = dev_byte;
            SEL_STAT: rdata[BYTE_W-1:0] = stat;
            SEL_VECT: rdata[BYTE_W-1:0] = vect;
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mmio_out_port_chk.sv
module mmio_out_port_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              take,
   input logic              ready,
   input logic              pend,
   input logic              err,
   input logic              irq,
   input logic              dev_err,
   input logic              dev_valid,
   input logic              dev_accept,
   input logic [BYTE_W-1:0] dev_byte
);
   assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!ready && dev_valid));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && !dev_accept) |=> (dev_valid && $stable(dev_byte)));
   assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !dev_valid && !take) |=> $stable(dev_byte));
   assert_busy_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_valid |-> !ready);
   assert_pend_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> irq);
   assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dev_err |=> err);
endmodule

bind mmio_out_port mmio_out_port_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .take(take), .ready(ready), .pend(pend),
   .err(err), .irq(irq), .dev_err(dev_err), .dev_valid(dev_valid),
   .dev_accept(dev_accept), .dev_byte(dev_byte)
);

// File: tb/mmio_out_port_tb.sv
module mmio_out_port_tb;
   localparam logic [15:0] BASE = 16'h8000;
   localparam logic [15:0] A_BYTE = BASE;
   localparam logic [15:0] A_STAT = BASE + 16'd2;
   localparam logic [15:0] A_VECT = BASE + 16'd4;
   localparam logic [15:0] A_HOLE = BASE + 16'd6;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [15:0] addr = '0, wdata = '0, rdata;
   logic        wr_en = 1'b0, rd_en = 1'b0, iack = 1'b0;
   logic        dev_err = 1'b0, dev_accept = 1'b0;
   logic        irq, dev_valid;
   logic [7:0]  dev_byte;

   int checks = 0, errors = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   mmio_out_port #(.BASE(BASE), .SETTLE(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .iack(iack), .irq(irq), .dev_err(dev_err),
      .dev_accept(dev_accept), .dev_valid(dev_valid), .dev_byte(dev_byte)
   );

   // monitor: pops one expected value per bus read or acknowledge cycle
   always @(negedge clk) begin
      if (rd_en || iack) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read, actual %h expected none", rdata);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #2;
      rd_en = 1'b0;
   endtask

   task automatic ack(input logic [15:0] e, input string t);
      iack = 1'b1; rd_en = 1'b1; addr = A_STAT;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #2;
      iack = 1'b0; rd_en = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic accept();
      dev_accept = 1'b1;
      @(posedge clk); #2;
      dev_accept = 1'b0;
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] e, input string t);
      @(negedge clk);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", t, act, e);
      end
   endtask

   initial begin
      fork
         begin
            #1_000_000;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
         begin
            repeat (3) @(posedge clk);
            #2 rst_n = 1'b1;
            @(posedge clk); #2;
            // R1 reset state
            rd(A_STAT, 16'h0080, "R1 status");
            rd(A_VECT, 16'h000F, "R1 vector");
            chk({15'd0, irq}, 16'd0, "R1 irq");
            chk({15'd0, dev_valid}, 16'd0, "R1 dev_valid");
            // R3 polled write
            wr(A_BYTE, 16'h12A5);
            chk({15'd0, dev_valid}, 16'd1, "R3 dev_valid");
            chk({8'd0, dev_byte}, 16'h00A5, "R3 dev_byte");
            rd(A_STAT, 16'h0000, "R3 ready cleared");
            rd(A_BYTE, 16'h00A5, "R3 readback");
            // R4 write while busy
            wr(A_BYTE, 16'h003C);
            chk({8'd0, dev_byte}, 16'h00A5, "R4 dev_byte kept");
            rd(A_BYTE, 16'h00A5, "R4 readback kept");
            // R5 settle timing, R8 no pending while disabled
            accept();
            rd(A_STAT, 16'h0000, "R5 edge0");
            rd(A_STAT, 16'h0000, "R5 edge1");
            rd(A_STAT, 16'h0080, "R5 edge2 ready");
            rd(A_STAT, 16'h0080, "R8 no pending when disabled");
            // R6/R7 enable
            wr(A_STAT, 16'h0004);
            rd(A_STAT, 16'h0084, "R6 enable bit");
            chk({15'd0, irq}, 16'd1, "R7 irq high");
            // R10 vector
            wr(A_VECT, 16'h0040);
            rd(A_VECT, 16'h0040, "R2 vector offset");
            ack(16'h0040, "R10 iack vector");
            // R8 pending after rise while enabled
            wr(A_BYTE, 16'h0011);
            chk({15'd0, irq}, 16'd0, "R7 irq low when busy");
            accept();
            rd(A_STAT, 16'h0004, "R5 edge0 en");
            rd(A_STAT, 16'h0004, "R5 edge1 en");
            rd(A_STAT, 16'h0084, "R8 ready before pending");
            rd(A_STAT, 16'h0086, "R8 pending set");
            chk({15'd0, irq}, 16'd1, "R7 irq with pending");
            wr(A_BYTE, 16'h0022);
            rd(A_STAT, 16'h0004, "R8 pending cleared by write");
            // R9 error
            dev_err = 1'b1;
            @(posedge clk); #2;
            dev_err = 1'b0;
            rd(A_STAT, 16'h0005, "R9 error set");
            wr(A_STAT, 16'h0085);
            rd(A_STAT, 16'h0005, "R9 write 1 keeps, R6 ready not writable");
            // R2 unmapped
            wr(A_HOLE, 16'h0000);
            rd(A_STAT, 16'h0005, "R2 hole write ignored");
            rd(A_HOLE, 16'h0000, "R2 hole reads zero");
            wr(A_STAT, 16'h0004);
            rd(A_STAT, 16'h0004, "R9 error cleared");
            chk({8'd0, dev_byte}, 16'h0022, "R3 second byte");
         end
      join_any
      disable fork;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule